// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches one tearing-effect input coming from a display panel. The panel sends both its horizontal and its vertical sync on that single pin, so the block tells the two apart by how long each pulse lasts. It measures that width in ticks of a programmable clock divider and compares it with two thresholds. When a programmed condition is met, the block drives a one-cycle low pulse on an active-low interrupt line. A frame transfer that is waiting for a safe moment to start can be released on the falling edge of that line.

Two matching modes exist. In vertical-only mode, every vertical sync gives a match. In line mode, the block counts horizontal pulses after each vertical sync and gives one match per frame when that count reaches a programmed line number. Line 0 means the vertical sync itself. Each of the two classifiers has its own polarity-invert bit. A master enable and the mode field together decide whether the detector runs.

Top module: `te_sync_detect`

## Requirements
- R1: After reset, `match_irq_n` is high, and it stays high while no sync pulse has been classified.
- R2: One tick is produced every `cfg_clk_div + 1` clock cycles. Pulse widths are counted as the number of ticks that fall in cycles where the synchronised pin is at its active level.
- R3: A pulse lasting at least `cfg_hs_width + 1` ticks, but fewer ticks than the vertical threshold, is a horizontal sync. A pulse shorter than `cfg_hs_width + 1` ticks is ignored.
- R4: A pulse lasting at least `(cfg_vs_width + 1) * 8` ticks is a vertical sync and is never also taken as a horizontal sync.
- R5: The horizontal classifier sees the pin as active when `te_pin XOR cfg_hs_inv` is 1. The vertical classifier sees it as active when `te_pin XOR cfg_vs_inv` is 1. The two bits act independently.
- R6: With `cfg_mode` = 3 (vertical only), every vertical sync gives exactly one match, and horizontal syncs give none.
- R7: With `cfg_mode` = 2 (line mode), a vertical sync sets the line count to 0 and each following horizontal sync adds 1. Exactly one match is given per frame, on the horizontal sync that brings the count to `cfg_line`.
- R8: In line mode with `cfg_line` = 0, the vertical sync itself gives the match, and the horizontal syncs of that frame give none.
- R9: No match is given when `cfg_te_en` is 0, or when `cfg_mode` is 0 (off) or 1 (reserved).
- R10: A match is signalled by driving `match_irq_n` low for exactly one clock cycle. The low pulse begins four clock edges after the pin transition that ends the matching pulse.
- R11: In line mode, horizontal syncs that arrive after enabling but before the first vertical sync are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| te_pin | input | 1 | Tearing-effect input from the panel (asynchronous) |
| cfg_te_en | input | 1 | Master enable of the detector |
| cfg_mode | input | 2 | 0 off, 1 reserved, 2 line mode, 3 vertical only |
| cfg_line | input | 11 | Target line number for line mode |
| cfg_hs_width | input | 3 | Horizontal threshold, in ticks minus 1 |
| cfg_vs_width | input | 12 | Vertical threshold, in units of 8 ticks, minus 1 |
| cfg_hs_inv | input | 1 | Invert the pin for the horizontal classifier |
| cfg_vs_inv | input | 1 | Invert the pin for the vertical classifier |
| cfg_clk_div | input | 3 | Tick divider, in cycles minus 1 |
| match_irq_n | output | 1 | Active-low one-cycle match pulse |

## Verification
The case of interest is when the polarities differ. Then the vertical classifier sees its pulse end in the very cycle that the horizontal classifier sees its pulse begin. So the line counter is cleared in the same cycle that the first counted line starts to be measured.

The bench provokes this by giving the vertical classifier the low level as active and the horizontal classifier the high level. It sends a long low stretch followed directly by short high pulses. The result is judged by a match on exactly the second high pulse, and on no other pulse.

A second coincidence is a divider tick landing on a pulse's first or last cycle. With a divide-by-four setting, pulses of 60 and 64 cycles must fall on either side of a 16-tick threshold whatever the divider phase. Pulses of 28 and 32 cycles must fall on either side of an 8-tick threshold in the same way.

// File: rtl/te_sync_pkg.sv
`timescale 1ns/1ps
package te_sync_pkg;

    localparam int LINE_W = 11;
    localparam int HTH_W  = 3;
    localparam int VTH_W  = 12;
    localparam int DIV_W  = 3;
    localparam int CNT_W  = VTH_W + 4;

    typedef enum logic [1:0] {
        TE_OFF   = 2'd0,
        TE_RSVD  = 2'd1,
        TE_LINE  = 2'd2,
        TE_VONLY = 2'd3
    } te_mode_e;

    typedef struct packed {
        logic vsync;
        logic hsync;
    } te_event_t;

    // horizontal threshold in ticks: field + 1
    function automatic logic [CNT_W-1:0] hs_ticks(input logic [HTH_W-1:0] f);
        return {{(CNT_W-HTH_W){1'b0}}, f} + {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

    // vertical threshold in ticks: (field + 1) * 8
    function automatic logic [CNT_W-1:0] vs_ticks(input logic [VTH_W-1:0] f);
        logic [VTH_W:0] units;
        units = {1'b0, f} + {{VTH_W{1'b0}}, 1'b1};
        return {units, 3'b000};
    endfunction

    function automatic te_mode_e to_mode(input logic [1:0] raw);
        return te_mode_e'(raw);
    endfunction

endpackage

// File: rtl/te_tick_gen.sv
`timescale 1ns/1ps
module te_tick_gen #(
    parameter int DIV_W = te_sync_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // ">=" keeps the divider sane when the setting shrinks mid-count
    assign tick_o = (cnt_q >= div_m1_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: with a divide setting above one, ticks are never back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_m1_i != '0) ##1 $stable(div_m1_i) |-> !tick_o);

endmodule

// File: rtl/te_width_chan.sv
`timescale 1ns/1ps
module te_width_chan #(
    parameter int CNT_W   = te_sync_pkg::CNT_W,
    parameter bit BOUNDED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             pin_i,
    input  logic             inv_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             hit_o
);
    logic             act;
    logic             act_q;
    logic             seen_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trail;
    logic             in_range;

    assign act      = pin_i ^ inv_i;
    assign trail    = act_q && !act;
    assign in_range = (cnt_q >= lo_i) && (!BOUNDED || (cnt_q < hi_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            // start as if active so no edge is invented out of reset
            act_q  <= 1'b1;
            seen_q <= 1'b0;
            cnt_q  <= '0;
            hit_o  <= 1'b0;
        end else begin
            act_q <= act;
            hit_o <= run_i && seen_q && trail && in_range;

            if (!run_i || !act) begin
                seen_q <= 1'b0;
            end else if (!act_q) begin
                seen_q <= 1'b1;
            end

            if (!act) begin
                cnt_q <= '0;
            end else if (tick_i && (cnt_q != '1)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: no pulse is reported unless the channel was running
    p_hit_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(run_i));

endmodule

// File: rtl/te_line_match.sv
`timescale 1ns/1ps
module te_line_match
    import te_sync_pkg::*;
#(
    parameter int LW = te_sync_pkg::LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  te_mode_e      mode_i,
    input  logic [LW-1:0] line_i,
    input  te_event_t     ev_i,
    output logic          irq_n_o
);
    logic [LW-1:0] cnt_q, cnt_d, cnt_inc;
    logic          framed_q, framed_d;
    logic          fired_q, fired_d;
    logic          match;

    assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

    always_comb begin
        cnt_d    = cnt_q;
        framed_d = framed_q;
        fired_d  = fired_q;
        match    = 1'b0;
        if (!run_i) begin
            cnt_d    = '0;
            framed_d = 1'b0;
            fired_d  = 1'b0;
        end else if (ev_i.vsync) begin
            cnt_d    = '0;
            framed_d = 1'b1;
            if (mode_i == TE_VONLY) begin
                match = 1'b1;
            end else if (line_i == '0) begin
                match   = 1'b1;
                fired_d = 1'b1;
            end else begin
                fired_d = 1'b0;
            end
        end else if (ev_i.hsync && framed_q && (mode_i == TE_LINE)) begin
            cnt_d = cnt_inc;
            if (!fired_q && (cnt_inc == line_i)) begin
                match   = 1'b1;
                fired_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            framed_q <= 1'b0;
            fired_q  <= 1'b0;
            irq_n_o  <= 1'b1;
        end else begin
            cnt_q    <= cnt_d;
            framed_q <= framed_d;
            fired_q  <= fired_d;
            irq_n_o  <= !match;
        end
    end

    // R4: the two classifiers never report in the same cycle
    p_hv_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(ev_i.hsync && ev_i.vsync));

    // R7: once a frame has matched in line mode, only a new vertical sync re-arms
    p_once_per_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (run_i && mode_i == TE_LINE && fired_q && !ev_i.vsync) |-> !match);

    // R7: a vertical sync restarts the line count
    p_line_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (run_i && ev_i.vsync) |=> (cnt_q == '0));

endmodule

// File: rtl/te_sync_detect.sv
`timescale 1ns/1ps
module te_sync_detect
    import te_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               te_pin,
    input  logic               cfg_te_en,
    input  logic [1:0]         cfg_mode,
    input  logic [LINE_W-1:0]  cfg_line,
    input  logic [HTH_W-1:0]   cfg_hs_width,
    input  logic [VTH_W-1:0]   cfg_vs_width,
    input  logic               cfg_hs_inv,
    input  logic               cfg_vs_inv,
    input  logic [DIV_W-1:0]   cfg_clk_div,
    output logic               match_irq_n
);
    localparam int NCH = 2;   // channel 0 horizontal, channel 1 vertical

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   tick;
    logic                   run;
    te_mode_e               mode;
    te_event_t              ev;
    logic [CNT_W-1:0]       hs_thr, vs_thr;
    logic [NCH-1:0]         inv_a;
    logic [NCH-1:0]         hit_a;
    logic [CNT_W-1:0]       lo_a [NCH];
    logic [CNT_W-1:0]       hi_a [NCH];

    genvar gs;
    generate
        for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[gs] <= 1'b0;
                end else if (gs == 0) begin
                    sync_q[gs] <= te_pin;
                end else begin
                    sync_q[gs] <= sync_q[(gs == 0) ? 0 : gs-1];
                end
            end
        end
    endgenerate

    assign pin_s  = sync_q[SYNC_STAGES-1];
    assign mode   = to_mode(cfg_mode);
    assign run    = cfg_te_en && ((mode == TE_LINE) || (mode == TE_VONLY));
    assign hs_thr = hs_ticks(cfg_hs_width);
    assign vs_thr = vs_ticks(cfg_vs_width);

    assign inv_a  = {cfg_vs_inv, cfg_hs_inv};
    assign lo_a[0] = hs_thr;
    assign hi_a[0] = vs_thr;
    assign lo_a[1] = vs_thr;
    assign hi_a[1] = vs_thr;

    te_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .div_m1_i (cfg_clk_div),
        .tick_o   (tick)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_chan
            te_width_chan #(.CNT_W(CNT_W), .BOUNDED(gc == 0)) u_chan (
                .clk    (clk),
                .rst    (rst),
                .run_i  (run),
                .pin_i  (pin_s),
                .inv_i  (inv_a[gc]),
                .tick_i (tick),
                .lo_i   (lo_a[gc]),
                .hi_i   (hi_a[gc]),
                .hit_o  (hit_a[gc])
            );
        end
    endgenerate

    assign ev.hsync = hit_a[0];
    assign ev.vsync = hit_a[1];

    te_line_match #(.LW(LINE_W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .mode_i  (mode),
        .line_i  (cfg_line),
        .ev_i    (ev),
        .irq_n_o (match_irq_n)
    );

    // R9: a match pulse only follows a cycle with the detector enabled in a live mode
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        !match_irq_n |-> $past(cfg_te_en && cfg_mode[1]));

    // R10: the interrupt is low for a single cycle
    p_irq_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        !match_irq_n |=> match_irq_n);

endmodule

// File: tb/te_sync_detect_bench.sv
`timescale 1ns/1ps
module te_sync_detect_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        te_pin = 1'b0;
    logic        cfg_te_en = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [10:0] cfg_line = '0;
    logic [2:0]  cfg_hs_width = 3'd7;   // 8 ticks
    logic [11:0] cfg_vs_width = 12'd1;  // 16 ticks
    logic        cfg_hs_inv = 1'b0;
    logic        cfg_vs_inv = 1'b0;
    logic [2:0]  cfg_clk_div = 3'd0;
    logic        match_irq_n;

    always #5 clk = ~clk;

    te_sync_detect u_te_sync_detect (
        .clk          (clk),
        .rst          (rst),
        .te_pin       (te_pin),
        .cfg_te_en    (cfg_te_en),
        .cfg_mode     (cfg_mode),
        .cfg_line     (cfg_line),
        .cfg_hs_width (cfg_hs_width),
        .cfg_vs_width (cfg_vs_width),
        .cfg_hs_inv   (cfg_hs_inv),
        .cfg_vs_inv   (cfg_vs_inv),
        .cfg_clk_div  (cfg_clk_div),
        .match_irq_n  (match_irq_n)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cur_seg = 0;
    int    exp_id[$];
    string exp_tag[$];
    string phase_tag = "R1";
    logic  prev_low = 1'b0;
    int    got_id;
    string got_tag;
    bit    done = 1'b0;

    // driver: hold the pin at lvl for n cycles; expect a match from this segment's end
    task automatic seg(input logic lvl, input int n, input bit expect_match, input string tag);
        @(posedge clk); #1;
        cur_seg++;
        te_pin = lvl;
        if (expect_match) begin
            exp_id.push_back(cur_seg);
            exp_tag.push_back(tag);
        end
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic set_cfg(input logic en, input logic [1:0] md, input logic [10:0] ln,
                           input logic hinv, input logic vinv, input logic [2:0] dv,
                           input logic idle, input string tag);
        @(posedge clk); #1;
        cfg_te_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        cfg_mode = md; cfg_line = ln; cfg_hs_inv = hinv; cfg_vs_inv = vinv;
        cfg_clk_div = dv; te_pin = idle; phase_tag = tag;
        repeat (6) @(posedge clk);
        #1;
        cfg_te_en = en;
        repeat (2) @(posedge clk);
    endtask

    task automatic check_drained(input string tag);
        repeat (8) @(posedge clk);
        n_chk++;
        if (exp_id.size() != 0) begin
            n_bad++;
            $display("FAIL %s: missing matches, actual pending=%0d expected=0", tag, exp_id.size());
            exp_id.delete();
            exp_tag.delete();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_low) begin
                n_chk++;
                if (!match_irq_n) begin
                    n_bad++;
                    $display("FAIL R10: irq low for more than one cycle, actual=0 expected=1");
                end
            end
            if (!match_irq_n) begin
                n_chk++;
                if (exp_id.size() == 0) begin
                    n_bad++;
                    $display("FAIL %s: unexpected match after segment %0d, actual=match expected=none",
                             phase_tag, cur_seg - 1);
                end else begin
                    got_id  = exp_id.pop_front();
                    got_tag = exp_tag.pop_front();
                    if (got_id != cur_seg - 1) begin
                        n_bad++;
                        $display("FAIL %s: match attributed to segment actual=%0d expected=%0d",
                                 got_tag, cur_seg - 1, got_id);
                    end
                end
            end
            prev_low = !match_irq_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        // R1: idle high after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n_chk++;
            if (match_irq_n !== 1'b1) begin
                n_bad++;
                $display("FAIL R1: irq after reset actual=%b expected=1", match_irq_n);
            end
        end

        // R6, R3, R4: vertical-only mode, div 1, thresholds 8 / 16 ticks
        set_cfg(1'b1, 2'd3, 11'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R6");
        seg(1'b0, 10, 1'b0, "R6");
        seg(1'b1, 7,  1'b0, "R3");  // too narrow
        seg(1'b0, 10, 1'b0, "R6");
        seg(1'b1, 8,  1'b0, "R6");  // horizontal, no match in this mode
        seg(1'b0, 10, 1'b0, "R6");
        seg(1'b1, 15, 1'b0, "R6");  // still horizontal
        seg(1'b0, 10, 1'b0, "R6");
        seg(1'b1, 16, 1'b1, "R4");  // vertical at threshold
        seg(1'b0, 10, 1'b0, "R6");
        seg(1'b1, 40, 1'b1, "R6");
        seg(1'b0, 10, 1'b0, "R6");
        check_drained("R6");

        // R11, R3, R4, R7: line mode target line 1
        set_cfg(1'b1, 2'd2, 11'd1, 1'b0, 1'b0, 3'd0, 1'b0, "R11");
        seg(1'b1, 8,  1'b0, "R11"); // horizontal before any vertical
        seg(1'b0, 10, 1'b0, "R11");
        seg(1'b1, 20, 1'b0, "R7");  // vertical
        seg(1'b0, 10, 1'b0, "R7");
        seg(1'b1, 7,  1'b0, "R3");  // ignored
        seg(1'b0, 10, 1'b0, "R3");
        seg(1'b1, 8,  1'b1, "R3");  // line 1
        seg(1'b0, 10, 1'b0, "R7");
        seg(1'b1, 8,  1'b0, "R7");  // line 2
        seg(1'b0, 10, 1'b0, "R7");
        seg(1'b1, 20, 1'b0, "R7");  // vertical
        seg(1'b0, 10, 1'b0, "R7");
        seg(1'b1, 15, 1'b1, "R3");  // widest horizontal
        seg(1'b0, 10, 1'b0, "R4");
        seg(1'b1, 16, 1'b0, "R4");  // vertical, restarts count
        seg(1'b0, 10, 1'b0, "R4");
        seg(1'b1, 8,  1'b1, "R4");
        seg(1'b0, 10, 1'b0, "R7");
        check_drained("R7");

        // R7: line 3, once per frame
        set_cfg(1'b1, 2'd2, 11'd3, 1'b0, 1'b0, 3'd0, 1'b0, "R7");
        for (int f = 0; f < 2; f++) begin
            seg(1'b1, 20, 1'b0, "R7");
            for (int h = 1; h <= 5; h++) begin
                seg(1'b0, 10, 1'b0, "R7");
                seg(1'b1, 8, (h == 3), "R7");
            end
            seg(1'b0, 10, 1'b0, "R7");
        end
        check_drained("R7");

        // R8: line 0 matches on the vertical sync
        set_cfg(1'b1, 2'd2, 11'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R8");
        seg(1'b1, 20, 1'b1, "R8");
        seg(1'b0, 10, 1'b0, "R8");
        seg(1'b1, 8,  1'b0, "R8");
        seg(1'b0, 10, 1'b0, "R8");
        seg(1'b1, 8,  1'b0, "R8");
        seg(1'b0, 10, 1'b0, "R8");
        seg(1'b1, 20, 1'b1, "R8");
        seg(1'b0, 10, 1'b0, "R8");
        check_drained("R8");

        // R9: off, reserved, and enable low
        set_cfg(1'b1, 2'd0, 11'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R9");
        seg(1'b1, 20, 1'b0, "R9"); seg(1'b0, 10, 1'b0, "R9");
        seg(1'b1, 8,  1'b0, "R9"); seg(1'b0, 10, 1'b0, "R9");
        set_cfg(1'b1, 2'd1, 11'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R9");
        seg(1'b1, 20, 1'b0, "R9"); seg(1'b0, 10, 1'b0, "R9");
        seg(1'b1, 8,  1'b0, "R9"); seg(1'b0, 10, 1'b0, "R9");
        set_cfg(1'b0, 2'd3, 11'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R9");
        seg(1'b1, 20, 1'b0, "R9"); seg(1'b0, 10, 1'b0, "R9");
        check_drained("R9");

        // R5: both classifiers inverted, pin idles high
        set_cfg(1'b1, 2'd3, 11'd0, 1'b1, 1'b1, 3'd0, 1'b1, "R5");
        seg(1'b1, 10, 1'b0, "R5");
        seg(1'b0, 16, 1'b1, "R5");
        seg(1'b1, 10, 1'b0, "R5");
        seg(1'b0, 8,  1'b0, "R5");
        seg(1'b1, 10, 1'b0, "R5");
        set_cfg(1'b1, 2'd2, 11'd1, 1'b1, 1'b1, 3'd0, 1'b1, "R5");
        seg(1'b0, 20, 1'b0, "R5");
        seg(1'b1, 10, 1'b0, "R5");
        seg(1'b0, 8,  1'b1, "R5");
        seg(1'b1, 10, 1'b0, "R5");
        check_drained("R5");

        // R5, R7: mixed polarity; vertical = long low, horizontal = short high
        set_cfg(1'b1, 2'd2, 11'd2, 1'b0, 1'b1, 3'd0, 1'b0, "R5");
        seg(1'b1, 8,  1'b0, "R5");  // unframed horizontal
        seg(1'b0, 20, 1'b0, "R5");  // vertical, reported at its end
        seg(1'b1, 8,  1'b0, "R5");  // line 1
        seg(1'b0, 10, 1'b0, "R5");
        seg(1'b1, 8,  1'b1, "R5");  // line 2
        seg(1'b0, 10, 1'b0, "R5");
        check_drained("R5");

        // R2: divide by 4; 16-tick and 8-tick boundaries regardless of phase
        set_cfg(1'b1, 2'd3, 11'd0, 1'b0, 1'b0, 3'd3, 1'b0, "R2");
        seg(1'b0, 20, 1'b0, "R2");
        seg(1'b1, 80, 1'b1, "R2");
        seg(1'b0, 20, 1'b0, "R2");
        seg(1'b1, 40, 1'b0, "R2");
        seg(1'b0, 20, 1'b0, "R2");
        seg(1'b1, 60, 1'b0, "R2");  // 15 ticks
        seg(1'b0, 20, 1'b0, "R2");
        seg(1'b1, 64, 1'b1, "R2");  // 16 ticks
        seg(1'b0, 20, 1'b0, "R2");
        set_cfg(1'b1, 2'd2, 11'd1, 1'b0, 1'b0, 3'd3, 1'b0, "R2");
        seg(1'b1, 80, 1'b0, "R2");
        seg(1'b0, 20, 1'b0, "R2");
        seg(1'b1, 28, 1'b0, "R2");  // 7 ticks
        seg(1'b0, 20, 1'b0, "R2");
        seg(1'b1, 32, 1'b1, "R2");  // 8 ticks
        seg(1'b0, 20, 1'b0, "R2");
        check_drained("R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule